// File: doc/BRIEF.md
# Four-Channel Fixed-Priority DMA Engine

This block moves data on a chip's synchronous memory bus without the CPU. Each of its four channels holds a source address, a destination address, a byte count and a control word, all loaded through a small register port. A channel is started by an on-chip peripheral request line or by a software start bit. Before it touches the bus, the engine asks the bus arbiter for mastership through a request/grant pair. Once granted, it picks one channel by fixed priority. It then runs the transfer and hands the bus back.

A transfer takes one of two forms. In a flyby transfer, one memory cycle happens while the peripheral is acknowledged, and the peripheral drives or takes the data itself. In a memory-to-memory transfer, the engine runs a read cycle into an internal holding register and then a write cycle. The acknowledge is asserted only in the cycle that touches the peripheral side. Under the continuous bus policy, a channel keeps the bus for as long as its request stays active. Under the single policy, the bus is released after every transfer. When a block finishes, the channel sets a sticky status bit, and that bit can raise the interrupt.

Top module: `dma4_engine`

## Requirements
- R1: `bus_req` is low out of reset and whenever no channel is being served. `mem_valid` and `dma_ack` are only ever high while `bus_gnt` is high, and `bus_req` drops once servicing ends.
- R2: Channel priority is fixed, with channel 0 the highest and channel 3 the lowest. The winner is chosen in the cycle before the first bus cycle and is held for the whole transfer.
- R3: When control bit 1 is 0 (flyby), each transfer is one bus cycle. If control bit 10 is 0 (peripheral on the source side), that cycle is a memory write at the destination address. If control bit 10 is 1, it is a memory read at the source address.
- R4: When control bit 1 is 1 (memory-to-memory), each transfer is a read at the source address followed in the next cycle by a write of the read data at the destination address.
- R5: `dma_ack` has at most one bit set, and only the serviced channel's bit. It is high only during the bus cycle on the peripheral side. That is the read cycle when control bit 10 is 0, the write cycle when bit 10 is 1, and every flyby cycle.
- R6: Each transfer lowers the count by the step. The step is 1 byte when control bit 5 is 0 and 2 bytes when bit 5 is 1. When the count reaches zero, control bit 15 (done) is set and the bus is released.
- R7: With control bit 2 set (continuous), `bus_req` stays high for the whole block while the request stays active. With bit 2 clear, `bus_req` drops after every transfer.
- R8: Control bits 7:6 select the source address update and bits 9:8 select the destination address update. The codes are 00 for freeze, 01 for add the step, 10 for subtract the step and 11 for freeze.
- R9: Control bit 4 selects the request line: 0 means `req_pri`, 1 means `req_sec`. The other line has no effect. Writing control bit 11 as 1 raises a software request, which stays set until the block ends or the channel is disabled.
- R10: While control bit 0 (enable) is 0, the channel ignores all requests. Clearing it mid-block stops the channel after the current transfer. In that case done stays clear and the count keeps the remaining bytes.
- R11: `irq` is high when any channel has done set together with control bit 3. Writing control with bit 15 set clears done.
- R12: A register address is {channel, index}. Index 0 is the source, 1 the destination, 2 the count and 3 the control word. Every register reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {channel, index} |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| req_pri | input | 4 | Primary peripheral request per channel |
| req_sec | input | 4 | Secondary peripheral request per channel |
| dma_ack | output | 4 | Peripheral acknowledge per channel |
| irq | output | 1 | Interrupt |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| mem_valid | output | 1 | Memory bus cycle active |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_half | output | 1 | Access size: 2 bytes (1) or 1 byte (0) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the read cycle |

## Verification
The bench raises two channels in the same cycle and expects the order 0,0,3,3. A picker that reversed priority or re-arbitrated badly would interleave the channels or start with channel 3. It runs blocks that freeze the source, decrement the destination and use 2-byte steps against a bench model of the copy. A wrong step or a swapped address mode shows up as corrupted memory or wrong final addresses. It also clears enable in the middle of a block. A design that broke off a read/write pair would leave unequal read and write counts, and one that set done or lost count would fail the register read-back. Further cases hold the unselected request line active, drive a disabled channel, and count bus_req rises under both bus policies.

// File: rtl/dma4_pkg.sv
// Shared definitions for the four-channel DMA engine: control word bit
// positions, register indices and the sequencer state type.
package dma4_pkg;
    localparam int B_EN    = 0;   // channel enable
    localparam int B_M2M   = 1;   // 1: memory-to-memory, 0: flyby
    localparam int B_CONT  = 2;   // continuous bus policy
    localparam int B_IE    = 3;   // interrupt enable
    localparam int B_SEL2  = 4;   // select secondary request line
    localparam int B_HALF  = 5;   // 2-byte transfers
    localparam int B_SRCM  = 6;   // source address mode, 2 bits
    localparam int B_DSTM  = 8;   // destination address mode, 2 bits
    localparam int B_PSIDE = 10;  // peripheral on destination side
    localparam int B_GO    = 11;  // software request
    localparam int B_DONE  = 15;  // termination status
    localparam int CTRL_STORED = 11;

    localparam logic [1:0] IDX_SRC  = 2'd0;
    localparam logic [1:0] IDX_DST  = 2'd1;
    localparam logic [1:0] IDX_CNT  = 2'd2;
    localparam logic [1:0] IDX_CTRL = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT, S_ARB, S_XA, S_XB, S_SAMP
    } seq_state_t;
endpackage

// File: rtl/dma4_chan.sv
// One DMA channel: its register bank, address/count update and request
// qualification. Assumes DW >= 16 so the control word fits. A hardware
// update arriving in the same cycle as a software write takes precedence.
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          preq_i,
    input  logic          sreq_i,
    input  logic          upd_i,
    output logic [DW-1:0] src_o,
    output logic [DW-1:0] dst_o,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] ctrl_o,
    output logic          pend_o,
    output logic          done_o,
    output logic          ie_o
);
    logic [DW-1:0]          src_q, dst_q, cnt_q;
    logic [CTRL_STORED-1:0] ctrl_q;
    logic                   sw_q, done_q;
    logic [DW-1:0]          step;
    logic                   last;

    // Address advance for one transfer under the given mode.
    function automatic logic [DW-1:0] advance(input logic [DW-1:0] a,
                                              input logic [1:0] m,
                                              input logic [DW-1:0] s);
        case (m)
            2'b01:   return a + s;
            2'b10:   return a - s;
            default: return a;
        endcase
    endfunction

    // Step size and last-transfer detection.
    always_comb begin
        step = ctrl_q[B_HALF] ? DW'(2) : DW'(1);
        last = (cnt_q <= step);
    end

    // Register bank: software writes, then hardware transfer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
            sw_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_idx)
                    IDX_SRC: src_q <= wr_data;
                    IDX_DST: dst_q <= wr_data;
                    IDX_CNT: cnt_q <= wr_data;
                    default: begin
                        ctrl_q <= wr_data[CTRL_STORED-1:0];
                        if (wr_data[B_DONE]) done_q <= 1'b0;
                        if (wr_data[B_GO])   sw_q   <= 1'b1;
                        if (!wr_data[B_EN])  sw_q   <= 1'b0;
                    end
                endcase
            end
            if (upd_i) begin
                src_q <= advance(src_q, ctrl_q[B_SRCM +: 2], step);
                dst_q <= advance(dst_q, ctrl_q[B_DSTM +: 2], step);
                cnt_q <= last ? '0 : cnt_q - step;
                if (last) begin
                    done_q <= 1'b1;
                    sw_q   <= 1'b0;
                end
            end
        end
    end

    // Request qualification and register views.
    always_comb begin
        pend_o = ctrl_q[B_EN] && (cnt_q != '0) &&
                 (sw_q || (ctrl_q[B_SEL2] ? sreq_i : preq_i));
        ctrl_o = '0;
        ctrl_o[CTRL_STORED-1:0] = ctrl_q;
        ctrl_o[B_GO]   = sw_q;
        ctrl_o[B_DONE] = done_q;
        src_o  = src_q;
        dst_o  = dst_q;
        cnt_o  = cnt_q;
        done_o = done_q;
        ie_o   = ctrl_q[B_IE];
    end
endmodule

// File: rtl/dma4_prio.sv
// Fixed-priority picker: the lowest-numbered asserted request wins.
module dma4_prio #(
    parameter  int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic [CHW-1:0] idx,
    output logic           any
);
    // Scan from lowest priority up so the highest-priority hit is kept.
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/dma4_seq.sv
// Bus sequencer: obtains mastership, latches the winner one cycle before
// the first bus cycle, runs flyby or read/write cycles, drives the
// acknowledge on the peripheral-side cycle and releases the bus.
// Assumes the arbiter holds bus_gnt while bus_req stays high and that
// memory returns read data in the cycle of the read.
module dma4_seq
    import dma4_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int DW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_gnt,
    input  logic [NCH-1:0] pend,
    input  logic [CHW-1:0] pick_idx,
    input  logic           pick_any,
    input  logic           sel_m2m,
    input  logic           sel_cont,
    input  logic           sel_pside,
    input  logic           sel_half,
    input  logic [DW-1:0]  sel_src,
    input  logic [DW-1:0]  sel_dst,
    input  logic [DW-1:0]  mem_rdata,
    output logic           bus_req,
    output logic [CHW-1:0] win,
    output logic           arb_ld,
    output logic           mem_valid,
    output logic           mem_we,
    output logic           mem_half,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic [NCH-1:0] ack,
    output logic [NCH-1:0] upd
);
    seq_state_t    state_q, state_d;
    logic [CHW-1:0] win_q;
    logic [DW-1:0]  hold_q;
    logic           touch, xfer_end;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: if (pick_any) state_d = S_WAIT;
            S_WAIT: if (bus_gnt)  state_d = S_ARB;
            S_ARB:  state_d = pick_any ? S_XA : S_IDLE;
            S_XA:   state_d = sel_m2m ? S_XB : (sel_cont ? S_SAMP : S_IDLE);
            S_XB:   state_d = sel_cont ? S_SAMP : S_IDLE;
            S_SAMP: state_d = pend[win_q] ? S_XA : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Bus cycle outputs, acknowledge and per-channel update strobes.
    always_comb begin
        bus_req   = (state_q != S_IDLE);
        arb_ld    = (state_q == S_ARB) && pick_any;
        mem_valid = (state_q == S_XA) || (state_q == S_XB);
        mem_we    = (state_q == S_XB) || ((state_q == S_XA) && !sel_m2m && !sel_pside);
        mem_addr  = mem_we ? sel_dst : sel_src;
        mem_half  = sel_half;
        mem_wdata = hold_q;
        touch     = ((state_q == S_XA) && (!sel_m2m || !sel_pside)) ||
                    ((state_q == S_XB) && sel_pside);
        xfer_end  = ((state_q == S_XA) && !sel_m2m) || (state_q == S_XB);
        ack       = touch    ? (NCH'(1) << win_q) : '0;
        upd       = xfer_end ? (NCH'(1) << win_q) : '0;
        win       = win_q;
    end

    // State, winner latch and holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            win_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (arb_ld) win_q <= pick_idx;
            if ((state_q == S_XA) && sel_m2m) hold_q <= mem_rdata;
        end
    end
endmodule

// File: rtl/dma4_engine.sv
// Four-channel fixed-priority DMA engine top: register port decode,
// channel banks, priority picker and bus sequencer.
module dma4_engine
    import dma4_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int DW  = 16,
    localparam int CHW = $clog2(NCH),
    localparam int RAW = CHW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] req_pri,
    input  logic [NCH-1:0] req_sec,
    output logic [NCH-1:0] dma_ack,
    output logic           irq,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           mem_valid,
    output logic           mem_we,
    output logic           mem_half,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata
);
    logic [DW-1:0]  src_a  [NCH];
    logic [DW-1:0]  dst_a  [NCH];
    logic [DW-1:0]  cnt_a  [NCH];
    logic [DW-1:0]  ctrl_a [NCH];
    logic [NCH-1:0] pend_w, done_w, ie_w, upd_w;
    logic [CHW-1:0] pick_idx, win_w;
    logic           pick_any, arb_ld_w;
    logic [CHW-1:0] rsel;

    assign rsel = reg_addr[RAW-1:2];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma4_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && (rsel == CHW'(g))),
            .wr_idx  (reg_addr[1:0]),
            .wr_data (reg_wdata),
            .preq_i  (req_pri[g]),
            .sreq_i  (req_sec[g]),
            .upd_i   (upd_w[g]),
            .src_o   (src_a[g]),
            .dst_o   (dst_a[g]),
            .cnt_o   (cnt_a[g]),
            .ctrl_o  (ctrl_a[g]),
            .pend_o  (pend_w[g]),
            .done_o  (done_w[g]),
            .ie_o    (ie_w[g])
        );
    end

    dma4_prio #(.NCH(NCH)) u_prio (
        .req (pend_w),
        .idx (pick_idx),
        .any (pick_any)
    );

    dma4_seq #(.NCH(NCH), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_gnt   (bus_gnt),
        .pend      (pend_w),
        .pick_idx  (pick_idx),
        .pick_any  (pick_any),
        .sel_m2m   (ctrl_a[win_w][B_M2M]),
        .sel_cont  (ctrl_a[win_w][B_CONT]),
        .sel_pside (ctrl_a[win_w][B_PSIDE]),
        .sel_half  (ctrl_a[win_w][B_HALF]),
        .sel_src   (src_a[win_w]),
        .sel_dst   (dst_a[win_w]),
        .mem_rdata (mem_rdata),
        .bus_req   (bus_req),
        .win       (win_w),
        .arb_ld    (arb_ld_w),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_half  (mem_half),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ack       (dma_ack),
        .upd       (upd_w)
    );

    // Register read mux and interrupt combine.
    always_comb begin
        case (reg_addr[1:0])
            IDX_SRC: reg_rdata = src_a[rsel];
            IDX_DST: reg_rdata = dst_a[rsel];
            IDX_CNT: reg_rdata = cnt_a[rsel];
            default: reg_rdata = ctrl_a[rsel];
        endcase
        irq = |(done_w & ie_w);
    end
endmodule

// File: rtl/dma4_engine_chk.sv
// Protocol checker for dma4_engine, attached by bind.
module dma4_engine_chk #(
    parameter  int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_gnt,
    input logic           mem_valid,
    input logic [NCH-1:0] dma_ack,
    input logic           arb_ld_w,
    input logic [CHW-1:0] win_w,
    input logic [NCH-1:0] pend_w,
    input logic [NCH-1:0] done_w
);
    assert_mem_needs_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (bus_gnt && bus_req));

    assert_ack_needs_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack != '0) |-> (bus_gnt && mem_valid));

    assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_ack));

    assert_fixed_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arb_ld_w |=> ((($past(pend_w) >> win_w) & NCH'(1)) != '0) &&
                     (($past(pend_w) & ((NCH'(1) << win_w) - NCH'(1))) == '0));

    assert_done_after_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_w & ~$past(done_w)) != '0) |-> $past(mem_valid));
endmodule

bind dma4_engine dma4_engine_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_valid (mem_valid),
    .dma_ack   (dma_ack),
    .arb_ld_w  (arb_ld_w),
    .win_w     (win_w),
    .pend_w    (pend_w),
    .done_w    (done_w)
);

// File: tb/dma4_engine_test.sv
`timescale 1ns/1ps
module dma4_engine_test;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam logic [15:0] C_EN = 16'h0001, C_M2M = 16'h0002, C_CONT = 16'h0004,
        C_IE = 16'h0008, C_SEL2 = 16'h0010, C_HALF = 16'h0020, C_PS = 16'h0400,
        C_GO = 16'h0800, C_DONE = 16'h8000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [NCH-1:0] req_pri = '0, req_sec = '0, dma_ack;
    logic irq, bus_req, bus_gnt, mem_valid, mem_we, mem_half, cpu_hold;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    logic [7:0] mem [512];
    logic [7:0] refm [512];
    logic [15:0] log_addr [256];
    logic        log_we [256];
    logic [3:0]  log_ack [256];
    int log_n = 0, rises = 0, total = 0, failn = 0;
    logic prev_req = 1'b0;

    always #2.5 clk = ~clk;

    dma4_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_pri(req_pri),
        .req_sec(req_sec), .dma_ack(dma_ack), .irq(irq), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_half(mem_half), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Bus arbiter model: CPU may delay a grant but never revokes one.
    always @(posedge clk) begin
        if (!rst_n) bus_gnt <= 1'b0;
        else        bus_gnt <= bus_req && (bus_gnt || !cpu_hold);
    end
    initial begin
        cpu_hold = 1'b0;
        void'($urandom(77));
        forever begin
            @(negedge clk);
            cpu_hold = ($urandom % 4) == 0;
        end
    end

    // Memory model: read in the same cycle, write at the clock edge.
    always_comb begin
        mem_rdata = mem_half ? {mem[9'(mem_addr[8:0] + 9'd1)], mem[mem_addr[8:0]]}
                             : {8'h00, mem[mem_addr[8:0]]};
    end
    always @(posedge clk) begin
        if (mem_valid && mem_we) begin
            mem[mem_addr[8:0]] = mem_wdata[7:0];
            if (mem_half) mem[9'(mem_addr[8:0] + 9'd1)] = mem_wdata[15:8];
        end
    end

    // Bus monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (mem_valid && log_n < 256) begin
            log_addr[log_n] = mem_addr;
            log_we[log_n]   = mem_we;
            log_ack[log_n]  = dma_ack;
            log_n++;
        end
        if (bus_req && !prev_req) rises++;
        prev_req = bus_req;
    end

    task automatic clear_log();
        @(negedge clk);
        log_n = 0;
        rises = 0;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failn++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int idx, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = {2'(ch), 2'(idx)};
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int idx, output logic [15:0] d);
        @(negedge clk);
        reg_addr = {2'(ch), 2'(idx)};
        #1;
        d = reg_rdata;
    endtask

    task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] c, input logic [15:0] ctl);
        wr(ch, 0, s);
        wr(ch, 1, d);
        wr(ch, 2, c);
        wr(ch, 3, ctl);
    endtask

    task automatic wait_done(input int ch);
        logic [15:0] v;
        for (int k = 0; k < 3000; k++) begin
            rd(ch, 3, v);
            if (v[15]) break;
        end
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (!bus_req) break;
        end
    endtask

    function automatic logic [15:0] adv(input logic [15:0] a, input logic [1:0] m, input bit h);
        logic [15:0] s = h ? 16'd2 : 16'd1;
        case (m)
            2'b01:   return a + s;
            2'b10:   return a - s;
            default: return a;
        endcase
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'($urandom);
            refm[i] = mem[i];
        end
    endtask

    initial begin
        logic [15:0] v, v2;
        int bad, wn, rn;
        void'($urandom(2024));
        for (int i = 0; i < 512; i++) begin
            mem[i] = '0;
            refm[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R12, R11)
        check(bus_req == 1'b0 && dma_ack == '0, "R1 reset bus_req/ack", {bus_req, dma_ack}, 0);
        check(irq == 1'b0, "R11 reset irq", irq, 0);
        bad = 0;
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 4; i++) begin
                rd(c, i, v);
                if (v != 0) bad++;
            end
        check(bad == 0, "R12 registers zero after reset", bad, 0);

        // Memory-to-memory block, 2-byte steps, continuous, software start
        fill_mem();
        clear_log();
        setup(2, 16'h0010, 16'h0100, 16'd6,
              C_EN | C_M2M | C_CONT | C_IE | C_HALF | 16'h0040 | 16'h0100 | C_GO);
        wait_done(2);
        bad = 0;
        for (int i = 0; i < 6; i++) if (mem[9'h100 + i] != refm[9'h010 + i]) bad++;
        check(bad == 0, "R4 m2m copy contents", bad, 0);
        bad = 0;
        for (int k = 0; k < 3; k++) begin
            if (log_addr[2*k] != 16'h0010 + 16'(2*k) || log_we[2*k]) bad++;
            if (log_addr[2*k+1] != 16'h0100 + 16'(2*k) || !log_we[2*k+1]) bad++;
            if (log_ack[2*k] != 4'b0100 || log_ack[2*k+1] != 4'b0000) bad++;
        end
        check(log_n == 6 && bad == 0, "R4/R5 read-write order and ack side", log_n * 16 + bad, 6 * 16);
        check(rises == 1, "R7 continuous keeps bus", rises, 1);
        check(bus_req == 1'b0, "R1 bus released after block", bus_req, 0);
        rd(2, 3, v);
        check(v[15] && !v[11], "R6/R9 done set, software request cleared", v, 16'h8000);
        check(irq == 1'b1, "R11 irq from done and enable", irq, 1);
        rd(2, 2, v);
        check(v == 0, "R6 count reaches zero", v, 0);
        rd(2, 0, v);
        rd(2, 1, v2);
        check(v == 16'h0016 && v2 == 16'h0106, "R8 increment by two", {v, v2}, 32'h00160106);
        wr(2, 3, C_EN | C_M2M | C_IE | C_DONE);
        @(negedge clk);
        rd(2, 3, v);
        check(irq == 1'b0 && !v[15], "R11 write-one clears done", {irq, v[15]}, 0);

        // Priority with two flyby channels, single policy
        setup(0, 16'h0000, 16'h0180, 16'd2, C_EN | 16'h0100);
        setup(3, 16'h0000, 16'h01C0, 16'd2, C_EN | 16'h0100);
        clear_log();
        req_pri = 4'b1001;
        for (int k = 0; k < 400 && log_n < 4; k++) @(negedge clk);
        repeat (20) @(negedge clk);
        req_pri = '0;
        check(log_n == 4 && log_ack[0] == 4'b0001 && log_ack[1] == 4'b0001 &&
              log_ack[2] == 4'b1000 && log_ack[3] == 4'b1000,
              "R2 channel 0 served before channel 3", {log_ack[0], log_ack[2]}, 8'h18);
        check(log_we[0] && log_we[3] && log_addr[0] == 16'h0180 && log_addr[1] == 16'h0181 &&
              log_addr[2] == 16'h01C0 && log_addr[3] == 16'h01C1,
              "R3 flyby writes at destination", log_addr[2], 16'h01C0);
        check(rises == 4, "R7 single policy releases after each transfer", rises, 4);
        wr(0, 3, C_DONE);
        wr(3, 3, C_DONE);

        // Frozen source, decrementing destination, peripheral on destination side
        fill_mem();
        clear_log();
        setup(1, 16'h0050, 16'h00A0, 16'd3, C_EN | C_M2M | C_CONT | 16'h0200 | C_PS | C_GO);
        wait_done(1);
        bad = 0;
        for (int k = 0; k < 3; k++) begin
            if (log_addr[2*k] != 16'h0050 || log_we[2*k] || log_ack[2*k] != 4'b0000) bad++;
            if (log_addr[2*k+1] != 16'h00A0 - 16'(k) || !log_we[2*k+1] || log_ack[2*k+1] != 4'b0010) bad++;
        end
        check(log_n == 6 && bad == 0, "R8/R5 freeze and decrement, ack on write side", bad, 0);
        check(mem[9'h0A0] == refm[9'h050] && mem[9'h09F] == refm[9'h050] && mem[9'h09E] == refm[9'h050],
              "R4 frozen source copied", mem[9'h09E], refm[9'h050]);
        rd(1, 1, v);
        check(v == 16'h009D, "R8 destination after decrement", v, 16'h009D);
        wr(1, 3, C_DONE);

        // Secondary request select
        setup(3, 16'h0000, 16'h01E0, 16'd1, C_EN | C_SEL2 | 16'h0100);
        clear_log();
        req_pri[3] = 1'b1;
        repeat (30) @(negedge clk);
        check(log_n == 0 && rises == 0, "R9 unselected primary line ignored", log_n, 0);
        req_pri[3] = 1'b0;
        req_sec[3] = 1'b1;
        for (int k = 0; k < 200 && log_n < 1; k++) @(negedge clk);
        repeat (10) @(negedge clk);
        req_sec[3] = 1'b0;
        check(log_n == 1 && log_ack[0] == 4'b1000, "R9 secondary line triggers", log_n, 1);
        wr(3, 3, C_DONE);

        // Disabled channel ignores requests
        setup(0, 16'h0000, 16'h0190, 16'd4, 16'h0100);
        clear_log();
        req_pri[0] = 1'b1;
        repeat (30) @(negedge clk);
        req_pri[0] = 1'b0;
        rd(0, 2, v);
        check(log_n == 0 && v == 16'd4, "R10 disabled channel ignores request", {log_n[7:0], v[7:0]}, 16'h0004);

        // Clear enable in the middle of a block
        fill_mem();
        clear_log();
        setup(1, 16'h0000, 16'h0080, 16'd40, C_EN | C_M2M | C_CONT | 16'h0040 | 16'h0100 | C_GO);
        for (int k = 0; k < 400 && log_n < 6; k++) @(negedge clk);
        wr(1, 3, C_M2M | C_CONT | 16'h0040 | 16'h0100);
        repeat (12) @(negedge clk);
        wn = 0;
        rn = 0;
        for (int k = 0; k < log_n; k++) if (log_we[k]) wn++; else rn++;
        rd(1, 2, v);
        rd(1, 3, v2);
        check(bus_req == 1'b0 && rn == wn && wn < 40, "R10 stop after current transfer", rn * 256 + wn, rn * 257);
        check(v == 16'(40 - wn) && !v2[15], "R10 count kept, done clear", v, 40 - wn);

        // Randomized memory-to-memory blocks against a bench model
        for (int it = 0; it < 10; it++) begin
            int ch, cnt, n;
            bit h, cont, ps;
            logic [1:0] sm, dm;
            logic [15:0] s, d, s0, d0, ctl;
            ch = $urandom % 4;
            h = $urandom % 2;
            cont = $urandom % 2;
            ps = $urandom % 2;
            sm = 2'($urandom);
            dm = 2'($urandom);
            n = 1 + $urandom % 6;
            cnt = h ? 2 * n : n;
            n = cnt / (h ? 2 : 1);
            s0 = 16'(($urandom % 128) * 2);
            d0 = 16'h0100 + 16'(($urandom % 128) * 2);
            fill_mem();
            s = s0;
            d = d0;
            for (int k = 0; k < n; k++) begin
                refm[d[8:0]] = refm[s[8:0]];
                if (h) refm[9'(d[8:0] + 9'd1)] = refm[9'(s[8:0] + 9'd1)];
                s = adv(s, sm, h);
                d = adv(d, dm, h);
            end
            ctl = C_EN | C_M2M | C_GO | C_IE | (cont ? C_CONT : 16'h0) | (h ? C_HALF : 16'h0) |
                  (ps ? C_PS : 16'h0) | {6'h0, dm, sm, 6'h0};
            setup(ch, s0, d0, 16'(cnt), ctl);
            wait_done(ch);
            bad = 0;
            for (int i = 0; i < 512; i++) if (mem[i] != refm[i]) bad++;
            check(bad == 0, "R4/R8 random block contents", bad, 0);
            rd(ch, 0, v);
            rd(ch, 1, v2);
            check(v == s && v2 == d, "R8 random final addresses", {v, v2}, {s, d});
            rd(ch, 3, v);
            check(v[15] && irq, "R6 random block done", v[15], 1);
            wr(ch, 3, C_DONE);
        end

        $display("%0d/%0d checks passed", total - failn, total);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        failn++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", total - failn, total);
        $finish;
    end
endmodule